// File: doc/BRIEF.md
# Serial Shift Port with Edge Counter

This block is an 8-bit serial shift register coupled with a 4-bit clock counter, intended for a bus master on the same chip. The master reaches three registers through a small register-style port. They are a data register that is the live shift register itself, a control register, and a status register that holds the counter and a sticky overflow flag. The bus port is plain control access with no valid/ready handshake. A write completes in the cycle it is presented, and a read returns combinationally, so the port never applies back-pressure.

Each shift event moves the data register one place toward its most significant bit and loads the serial input into bit 0. The shift clock is chosen from one of four sources:
- a software strobe,
- a single-cycle timer compare-match pulse,
- the external serial clock pin, sampling on its rising edge,
- the external serial clock pin, sampling on its falling edge.

Bit 7 of the data register drives the serial output through a latch, so that input sampling and output change fall on opposite clock edges. When the external clock is selected, the counter advances on both of its edges. If the counter is preloaded to 15, a single pin edge sets the overflow flag, which lets the block serve as an extra edge-triggered interrupt source.

The serial clock and data pins pass through a synchronizer of `SYNC_STAGES` flops. All state changes happen on `clk`. With the default of two stages, a pin edge acts at the third rising edge of `clk` after the pin changes.

Top module: `shift_port_top`

## Requirements
- R1: Address 0 reads and writes the live shift register directly. A written value reads back unchanged when no shift occurs.
- R2: Each shift event moves the data register left by one. The old bit 7 is discarded and the synchronized serial input enters at bit 0.
- R3: Control bits [1:0] select the shift source: 00 software, 01 timer pulse, 10 external clock sampled on its rising edge, 11 external clock sampled on its falling edge. The software strobe is control bit 5, which is write-only and reads 0. It acts only when the select held before that write is 00. Strobes from sources that are not selected have no effect.
- R4: A data-register write in the same cycle as a shift event stores the written value and drops that shift. The counter still steps.
- R5: With an internal source (00 or 01), the counter steps once per accepted strobe. With an external source (10 or 11), it steps on both edges of the synchronized clock pin.
- R6: Status register layout: the overflow flag is bit 7 and the counter is bits [3:0]. The flag sets when the counter wraps from 15 to 0 and stays set. Writing the status register with bit 7 at 1 clears the flag, and writing 0 there leaves it unchanged. A status write loads the counter from bits [3:0], and that load takes priority over a step in the same cycle.
- R7: `irq` is high exactly when the overflow flag is set and the interrupt-enable bit (control bit 4) is 1.
- R8: `so` follows bit 7 of the data register through a latch. With an internal source, the latch is always transparent. With source 10, it is transparent while the synchronized clock is low and holds while it is high. With source 11, it is transparent while the synchronized clock is high and holds while it is low.
- R9: Control bits [3:2] set the wire mode: 01 is three-wire, and any other value means no output drive. `so_oe` is high only in three-wire mode. Shifting and counting use the pins in every wire mode.
- R10: After reset, the data register, counter, flag, control register, `so`, `so_oe` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 data, 1 control, 2 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`; unused addresses read 0 |
| sdi_pin | input | 1 | Serial data input (asynchronous) |
| sck_pin | input | 1 | External serial clock input (asynchronous) |
| tmr_match | input | 1 | Timer compare-match pulse, one cycle long |
| so | output | 1 | Serial data output through the output latch |
| so_oe | output | 1 | Output enable for the serial data pin |
| irq | output | 1 | Counter overflow interrupt request |

## Verification
The shift path is driven by the software strobe, by timer pulses, and by a full byte clocked in on rising pin edges. The byte has mixed bit values, so it separates a correct left shift from reversed or stuck bits. A single period sampled on the falling edge shows that the rising edge only counts and does not sample. A timer pulse that coincides with a data write shows whether the write or the shift wins. Preloading 15 and applying one pin edge shows wrap detection from a single edge. Writes to bit 7 while the clock is high and then low tell a holding latch apart from a transparent one.

// File: rtl/ssi_pkg.sv
package ssi_pkg;

  typedef enum logic [1:0] {
    SRC_SW       = 2'b00,
    SRC_TMR      = 2'b01,
    SRC_EXT_RISE = 2'b10,
    SRC_EXT_FALL = 2'b11
  } clk_src_e;

  typedef enum logic [1:0] {
    WM_NONE  = 2'b00,
    WM_THREE = 2'b01,
    WM_RSV2  = 2'b10,
    WM_RSV3  = 2'b11
  } wire_mode_e;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  localparam int CTRL_STB_BIT = 5;
  localparam int CTRL_IE_BIT  = 4;

endpackage

// File: rtl/ssi_pin_sync.sv
module ssi_pin_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_s_o
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= pin_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign pin_s_o = stage_q[STAGES-1];

endmodule

// File: rtl/ssi_clk_ctrl.sv
module ssi_clk_ctrl
  import ssi_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  clk_src_e src,
  input  logic     sck_s,
  input  logic     tmr_stb,
  input  logic     sw_stb,
  output logic     shift_evt,
  output logic     cnt_evt,
  output logic     transp
);

  logic sck_d_q;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d_q <= 1'b0;
    else        sck_d_q <= sck_s;
  end

  assign rise = sck_s & ~sck_d_q;
  assign fall = ~sck_s & sck_d_q;

  always_comb begin
    shift_evt = 1'b0;
    cnt_evt   = 1'b0;
    transp    = 1'b1;
    unique case (src)
      SRC_SW: begin
        shift_evt = sw_stb;
        cnt_evt   = sw_stb;
      end
      SRC_TMR: begin
        shift_evt = tmr_stb;
        cnt_evt   = tmr_stb;
      end
      SRC_EXT_RISE: begin
        shift_evt = rise;
        cnt_evt   = rise | fall;
        transp    = ~sck_s;
      end
      SRC_EXT_FALL: begin
        shift_evt = fall;
        cnt_evt   = rise | fall;
        transp    = sck_s;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ssi_counter.sv
module ssi_counter #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_val,
  input  logic          flag_clr,
  output logic [CW-1:0] cnt_o,
  output logic          flag_o
);

  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [CW-1:0] cnt_q;
  logic          flag_q;
  logic          wrap;

  assign wrap = step & ~wr_en & (cnt_q == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (wr_en) cnt_q <= wr_val;
    else if (step)  cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (wrap)     flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;

endmodule

// File: rtl/ssi_out_latch.sv
module ssi_out_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic transp,
  input  logic d,
  output logic q
);

  logic held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      held_q <= 1'b0;
    else if (transp) held_q <= d;
  end

  assign q = transp ? d : held_q;

endmodule

// File: rtl/shift_port_top.sv
module shift_port_top
  import ssi_pkg::*;
#(
  parameter int DW          = 8,
  parameter int CW          = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          sdi_pin,
  input  logic          sck_pin,
  input  logic          tmr_match,
  output logic          so,
  output logic          so_oe,
  output logic          irq
);

  localparam int STAT_PAD = DW - CW - 1;

  logic [DW-1:0] dr_q;
  logic          dr_wr, ctl_wr, st_wr;
  logic          sw_stb, flag_clr;
  clk_src_e      src_q;
  wire_mode_e    wm_q;
  logic          ie_q;
  logic [1:0]    pins_s;
  logic          sck_s, sdi_s;
  logic          shift_evt, cnt_evt, transp;
  logic [CW-1:0] cnt_q;
  logic          flag_q;

  assign dr_wr    = bus_wr & (bus_addr == ADDR_DATA);
  assign ctl_wr   = bus_wr & (bus_addr == ADDR_CTRL);
  assign st_wr    = bus_wr & (bus_addr == ADDR_STAT);
  assign sw_stb   = ctl_wr & bus_wdata[CTRL_STB_BIT];
  assign flag_clr = st_wr & bus_wdata[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= SRC_SW;
      wm_q  <= WM_NONE;
      ie_q  <= 1'b0;
    end else if (ctl_wr) begin
      src_q <= clk_src_e'(bus_wdata[1:0]);
      wm_q  <= wire_mode_e'(bus_wdata[3:2]);
      ie_q  <= bus_wdata[CTRL_IE_BIT];
    end
  end

  ssi_pin_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_i   ({sck_pin, sdi_pin}),
    .pin_s_o (pins_s)
  );
  assign sck_s = pins_s[1];
  assign sdi_s = pins_s[0];

  ssi_clk_ctrl u_clk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src       (src_q),
    .sck_s     (sck_s),
    .tmr_stb   (tmr_match),
    .sw_stb    (sw_stb),
    .shift_evt (shift_evt),
    .cnt_evt   (cnt_evt),
    .transp    (transp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dr_q <= '0;
    else if (dr_wr)     dr_q <= bus_wdata;
    else if (shift_evt) dr_q <= {dr_q[DW-2:0], sdi_s};
  end

  ssi_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (cnt_evt),
    .wr_en    (st_wr),
    .wr_val   (bus_wdata[CW-1:0]),
    .flag_clr (flag_clr),
    .cnt_o    (cnt_q),
    .flag_o   (flag_q)
  );

  ssi_out_latch u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .transp (transp),
    .d      (dr_q[DW-1]),
    .q      (so)
  );

  assign so_oe = (wm_q == WM_THREE);
  assign irq   = flag_q & ie_q;

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_DATA: bus_rdata = dr_q;
      ADDR_CTRL: begin
        bus_rdata[1:0]         = src_q;
        bus_rdata[3:2]         = wm_q;
        bus_rdata[CTRL_IE_BIT] = ie_q;
      end
      ADDR_STAT: bus_rdata = {flag_q, {STAT_PAD{1'b0}}, cnt_q};
      default:   bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/ssi_checker.sv
module ssi_checker #(
  parameter int DW = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] dr_q,
  input logic          dr_wr,
  input logic [DW-1:0] wdata,
  input logic          shift_evt,
  input logic          sdi_s,
  input logic          cnt_evt,
  input logic          st_wr,
  input logic [CW-1:0] cnt_q,
  input logic          flag_q,
  input logic          flag_clr,
  input logic          transp,
  input logic          so,
  input logic          irq
);

  localparam logic [CW-1:0] CMAX = '1;

  p_shift_left_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_evt && !dr_wr) |=> (dr_q == {$past(dr_q[DW-2:0]), $past(sdi_s)}));

  p_write_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dr_wr |=> (dr_q == $past(wdata)));

  p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_evt && !st_wr) |=> (cnt_q == CW'($past(cnt_q) + 1'b1)));

  p_ovf_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_evt && !st_wr && cnt_q == CMAX) |=> flag_q);

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);

  p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_q |-> !irq);

  p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !transp |=> (transp || $stable(so)));

endmodule

bind shift_port_top ssi_checker #(.DW(DW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dr_q      (dr_q),
  .dr_wr     (dr_wr),
  .wdata     (bus_wdata),
  .shift_evt (shift_evt),
  .sdi_s     (sdi_s),
  .cnt_evt   (cnt_evt),
  .st_wr     (st_wr),
  .cnt_q     (cnt_q),
  .flag_q    (flag_q),
  .flag_clr  (flag_clr),
  .transp    (transp),
  .so        (so),
  .irq       (irq)
);

// File: tb/shift_port_top_tb_top.sv
module shift_port_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       sdi_pin = 1'b0;
  logic       sck_pin = 1'b0;
  logic       tmr_match = 1'b0;
  logic       so, so_oe, irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  shift_port_top dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .sdi_pin   (sdi_pin),
    .sck_pin   (sck_pin),
    .tmr_match (tmr_match),
    .so        (so),
    .so_oe     (so_oe),
    .irq       (irq)
  );

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_sck(logic v);
    @(negedge clk);
    sck_pin = v;
    repeat (6) @(negedge clk);
  endtask

  task automatic set_sdi(logic v);
    @(negedge clk);
    sdi_pin = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic tmr_pulse();
    @(negedge clk);
    tmr_match = 1'b1;
    @(posedge clk); #1;
    tmr_match = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(2'd0, v); check("R10", "data after reset", v, 8'h00);
    rd(2'd2, v); check("R10", "status after reset", v, 8'h00);
    rd(2'd1, v); check("R10", "control after reset", v, 8'h00);
    check("R10", "so/so_oe/irq after reset", {5'b0, so, so_oe, irq}, 8'h00);
  endtask

  task automatic t_rw();
    logic [7:0] v;
    wr(2'd0, 8'hA5);
    rd(2'd0, v); check("R1", "data readback", v, 8'hA5);
  endtask

  task automatic t_sw_strobe();
    logic [7:0] v;
    wr(2'd2, 8'h80);
    wr(2'd0, 8'h81);
    set_sdi(1'b1);
    wr(2'd1, 8'h20);
    rd(2'd0, v); check("R2", "sw shift with sdi=1", v, 8'h03);
    rd(2'd2, v); check("R5", "count after one strobe", v, 8'h01);
    set_sdi(1'b0);
    wr(2'd1, 8'h20);
    rd(2'd0, v); check("R2", "sw shift with sdi=0", v, 8'h06);
    rd(2'd1, v); check("R3", "strobe bit reads 0", v, 8'h00);
  endtask

  task automatic t_timer();
    logic [7:0] v;
    wr(2'd1, 8'h01);
    wr(2'd1, 8'h21);
    rd(2'd0, v); check("R3", "sw strobe ignored under timer source", v, 8'h06);
    set_sdi(1'b1);
    tmr_pulse();
    rd(2'd0, v); check("R3", "timer shift", v, 8'h0D);
    rd(2'd2, v); check("R5", "count after timer shift", v, 8'h03);
  endtask

  task automatic t_coincide();
    logic [7:0] v;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h3C; tmr_match = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0; tmr_match = 1'b0;
    rd(2'd0, v); check("R4", "write wins over shift", v, 8'h3C);
    rd(2'd2, v); check("R4", "counter still steps", v, 8'h04);
  endtask

  task automatic t_ext_byte();
    logic [7:0] v;
    logic [7:0] pat = 8'hB6;
    wr(2'd1, 8'h16);
    wr(2'd2, 8'h80);
    check("R9", "so_oe in three-wire", {7'b0, so_oe}, 8'h01);
    for (int i = 7; i >= 0; i--) begin
      set_sdi(pat[i]);
      set_sck(1'b1);
      if (i > 0) set_sck(1'b0);
    end
    rd(2'd0, v); check("R2", "byte on rising edges", v, pat);
    rd(2'd2, v); check("R5", "15 edges counted", v, 8'h0F);
    set_sck(1'b0);
    rd(2'd2, v); check("R6", "wrap sets flag", v, 8'h80);
    check("R7", "irq with flag and enable", {7'b0, irq}, 8'h01);
    wr(2'd2, 8'h00);
    rd(2'd2, v); check("R6", "writing 0 keeps flag", v, 8'h80);
    wr(2'd2, 8'h80);
    rd(2'd2, v); check("R6", "write 1 clears flag", v, 8'h00);
    check("R7", "irq drops", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_ext_fall();
    logic [7:0] v;
    wr(2'd1, 8'h03);
    wr(2'd2, 8'h80);
    wr(2'd0, 8'h00);
    set_sdi(1'b1);
    set_sck(1'b1);
    rd(2'd0, v); check("R3", "no sample on rise in mode 11", v, 8'h00);
    set_sck(1'b0);
    rd(2'd0, v); check("R3", "sample on fall in mode 11", v, 8'h01);
    rd(2'd2, v); check("R5", "both edges counted", v, 8'h02);
    check("R9", "so_oe low in no-wire mode", {7'b0, so_oe}, 8'h00);
  endtask

  task automatic t_preload();
    logic [7:0] v;
    wr(2'd1, 8'h12);
    wr(2'd2, 8'h8F);
    set_sck(1'b1);
    rd(2'd2, v); check("R6", "preload 15 overflows on one edge", v, 8'h80);
    check("R7", "irq from single edge", {7'b0, irq}, 8'h01);
    set_sck(1'b0);
    wr(2'd2, 8'h80);
  endtask

  task automatic t_latch();
    logic [7:0] v;
    set_sdi(1'b0);
    wr(2'd1, 8'h02);
    wr(2'd0, 8'h80);
    @(negedge clk); check("R8", "transparent while sck low", {7'b0, so}, 8'h01);
    set_sck(1'b1);
    rd(2'd0, v); check("R8", "data shifted on rise", v, 8'h00);
    check("R8", "latch holds while sck high", {7'b0, so}, 8'h01);
    set_sck(1'b0);
    check("R8", "latch opens on fall", {7'b0, so}, 8'h00);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h80);
    @(negedge clk); check("R8", "internal source transparent (1)", {7'b0, so}, 8'h01);
    wr(2'd0, 8'h7F);
    @(negedge clk); check("R8", "internal source transparent (0)", {7'b0, so}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_rw();
    t_sw_strobe();
    t_timer();
    t_coincide();
    t_ext_byte();
    t_ext_fall();
    t_preload();
    t_latch();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule